// File: doc/BRIEF.md
# Addressed Serial Register Loader

This block lets a microcontroller program a bank of control registers, such as reference and channel divider values and mode bits, over three slow wires: a data line, a shift clock and a frame enable. A fast system clock samples all three wires through two-flop synchronizers and finds the edges of the synchronized copies. The serial bits are collected in a shift register. Each frame is closed when the enable line falls.

Every register write takes two frames. The first frame carries an 8-bit address, which goes into an address latch. The second frame carries up to 16 data bits, which go to the register that the latched address selects. The register contents are driven out in parallel. A one-cycle strobe and the target address mark each update.

The controller is a four-state machine that tracks both the phase (address or data) and whether a frame is open:
- `ST_ADDR_IDLE` moves to `ST_ADDR_SHIFT` on an enable rise, which clears the shift register.
- `ST_ADDR_SHIFT` moves to `ST_DATA_IDLE` on an enable fall, which loads the address latch.
- `ST_DATA_IDLE` moves to `ST_DATA_SHIFT` on an enable rise, which clears the shift register.
- `ST_DATA_SHIFT` moves to `ST_ADDR_IDLE` on an enable fall, which commits the data word.

In both shift states, each synchronized shift-clock rise moves one bit in. Any other event leaves the state unchanged.

Top module: `serial_reg_loader`

## Requirements
- R1: While the synchronous reset `rst` is high and right after it, every register reads 0, `wr_stb` is 0 and the machine is in `ST_ADDR_IDLE`.
- R2: A bit is taken from `ser_data` only on a rising edge of `ser_clk`. Bits enter MSB first: each new bit becomes bit 0 and earlier bits move up by one place.
- R3: Each falling edge of `ser_en` ends a frame. Frames alternate address, data, address, data, and so on, starting with an address frame.
- R4: The shift register is cleared on each rising edge of `ser_en`, so no bit of an earlier frame shows up in a later one.
- R5: When an address frame ends, the address latch takes the low 8 bits of the shift register. If more than 8 bits were sent, the last 8 bits sent are kept.
- R6: A data frame with fewer than 16 bits is right-justified, and its unused upper bits read 0. A data frame with more than 16 bits keeps its last 16 bits.
- R7: The bank holds 8 registers of 16 bits at addresses 0 to 7. Register k sits at bits [16k+15:16k] of `reg_flat`. A data frame sent to address 8 or higher changes no register and raises no strobe.
- R8: Each register update raises `wr_stb` for exactly one system cycle. In the same cycle, `wr_addr` holds the target address and `reg_flat` already shows the new value.
- R9: A reset between the address frame and the data frame cancels the pending write. The next frame is then taken as an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_data | input | 1 | Serial data line, asynchronous |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_en | input | 1 | Frame enable; a falling edge ends the frame |
| reg_flat | output | 128 | All 8 registers side by side; register k is at bits [16k+15:16k] |
| wr_stb | output | 1 | One-cycle pulse on each register update |
| wr_addr | output | 8 | Address of the update marked by `wr_stb` |

## Verification
The bench sends frames that are too short and frames that are too long. A design that did not clear the shift register between frames would leave stale upper bits in a short data word. A design that kept the first bits of a long frame instead of the last ones would store the wrong address or value. Writes to address 8 and above check that an out-of-range decode neither clobbers a register nor raises the strobe. A reset placed between the two frames of a write checks that the phase flag returns to address phase; a design that kept the old phase would treat the next address as data.

// File: rtl/srl_pkg.sv
package srl_pkg;
    typedef enum logic [1:0] {
        ST_ADDR_IDLE  = 2'd0,
        ST_ADDR_SHIFT = 2'd1,
        ST_DATA_IDLE  = 2'd2,
        ST_DATA_SHIFT = 2'd3
    } srl_state_e;
endpackage

// File: rtl/srl_sync.sv
module srl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/srl_fsm.sv
module srl_fsm
    import srl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_rise,
    input  logic       en_fall,
    input  logic       clk_rise,
    output logic       shift_clr,
    output logic       shift_en,
    output logic       addr_load,
    output logic       data_commit,
    output logic       phase_data,
    output srl_state_e state
);
    srl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ADDR_IDLE:  if (en_rise) state_d = ST_ADDR_SHIFT;
            ST_ADDR_SHIFT: if (en_fall) state_d = ST_DATA_IDLE;
            ST_DATA_IDLE:  if (en_rise) state_d = ST_DATA_SHIFT;
            ST_DATA_SHIFT: if (en_fall) state_d = ST_ADDR_IDLE;
            default:                    state_d = ST_ADDR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ADDR_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        shift_clr   = 1'b0;
        shift_en    = 1'b0;
        addr_load   = 1'b0;
        data_commit = 1'b0;
        phase_data  = 1'b0;
        unique case (state_q)
            ST_ADDR_IDLE: begin
                shift_clr = en_rise;
            end
            ST_ADDR_SHIFT: begin
                shift_en  = clk_rise;
                addr_load = en_fall;
            end
            ST_DATA_IDLE: begin
                shift_clr  = en_rise;
                phase_data = 1'b1;
            end
            ST_DATA_SHIFT: begin
                shift_en    = clk_rise;
                data_commit = en_fall;
                phase_data  = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/srl_shifter.sv
module srl_shifter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             shift,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word
);
    logic [WIDTH-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst || clr) word_q <= '0;
        else if (shift) word_q <= {word_q[WIDTH-2:0], bit_in};
    end

    assign word = word_q;
endmodule

// File: rtl/srl_regbank.sv
module srl_regbank #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       addr_load,
    input  logic                       data_commit,
    input  logic [DATA_W-1:0]          shift_word,
    output logic [NUM_REGS*DATA_W-1:0] reg_flat,
    output logic                       wr_stb,
    output logic [ADDR_W-1:0]          wr_addr
);
    logic [ADDR_W-1:0] addr_q;
    logic              in_range;
    logic              stb_q;
    logic [ADDR_W-1:0] stb_addr_q;

    assign in_range = (addr_q < ADDR_W'(NUM_REGS));

    always_ff @(posedge clk) begin
        if (rst)            addr_q <= '0;
        else if (addr_load) addr_q <= shift_word[ADDR_W-1:0];
    end

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            logic [DATA_W-1:0] val_q;
            always_ff @(posedge clk) begin
                if (rst)
                    val_q <= '0;
                else if (data_commit && addr_q == ADDR_W'(i))
                    val_q <= shift_word;
            end
            assign reg_flat[i*DATA_W +: DATA_W] = val_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q      <= 1'b0;
            stb_addr_q <= '0;
        end else begin
            stb_q <= data_commit && in_range;
            if (data_commit && in_range) stb_addr_q <= addr_q;
        end
    end

    assign wr_stb  = stb_q;
    assign wr_addr = stb_addr_q;
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
    import srl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ser_data,
    input  logic                       ser_clk,
    input  logic                       ser_en,
    output logic [NUM_REGS*DATA_W-1:0] reg_flat,
    output logic                       wr_stb,
    output logic [ADDR_W-1:0]          wr_addr
);
    localparam int SHIFT_W = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;

    logic       data_lvl, data_rise_unused, data_fall_unused;
    logic       sclk_lvl_unused, sclk_rise, sclk_fall_unused;
    logic       en_lvl_unused, en_rise, en_fall;
    logic       shift_clr, shift_en, addr_load, data_commit, phase_data;
    srl_state_e state;
    logic [SHIFT_W-1:0] shift_word;

    srl_sync #(.STAGES(SYNC_STAGES)) u_sync_data (
        .clk(clk), .rst(rst), .pin(ser_data),
        .level(data_lvl), .rise(data_rise_unused), .fall(data_fall_unused)
    );
    srl_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (
        .clk(clk), .rst(rst), .pin(ser_clk),
        .level(sclk_lvl_unused), .rise(sclk_rise), .fall(sclk_fall_unused)
    );
    srl_sync #(.STAGES(SYNC_STAGES)) u_sync_en (
        .clk(clk), .rst(rst), .pin(ser_en),
        .level(en_lvl_unused), .rise(en_rise), .fall(en_fall)
    );

    srl_fsm u_fsm (
        .clk(clk), .rst(rst),
        .en_rise(en_rise), .en_fall(en_fall), .clk_rise(sclk_rise),
        .shift_clr(shift_clr), .shift_en(shift_en),
        .addr_load(addr_load), .data_commit(data_commit),
        .phase_data(phase_data), .state(state)
    );

    srl_shifter #(.WIDTH(SHIFT_W)) u_shift (
        .clk(clk), .rst(rst), .clr(shift_clr), .shift(shift_en),
        .bit_in(data_lvl), .word(shift_word)
    );

    srl_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst(rst),
        .addr_load(addr_load), .data_commit(data_commit),
        .shift_word(shift_word[DATA_W-1:0]),
        .reg_flat(reg_flat), .wr_stb(wr_stb), .wr_addr(wr_addr)
    );
endmodule

// File: rtl/srl_checker.sv
module srl_checker #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8,
    parameter int SHIFT_W  = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       en_rise,
    input logic                       en_fall,
    input logic                       phase_data,
    input logic [SHIFT_W-1:0]         shift_word,
    input logic [NUM_REGS*DATA_W-1:0] reg_flat,
    input logic                       wr_stb,
    input logic [ADDR_W-1:0]          wr_addr
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (reg_flat == '0 && !wr_stb && !phase_data));

    // R3
    p_phase_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        en_fall |=> (phase_data != $past(phase_data)));

    // R4
    p_shift_clear_r4: assert property (@(posedge clk) disable iff (rst)
        en_rise |=> (shift_word == '0));

    // R7
    p_stb_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (wr_addr < ADDR_W'(NUM_REGS)));

    // R7, R8
    p_change_needs_stb_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(reg_flat) |-> wr_stb);

    // R8
    p_stb_single_r8: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);
endmodule

bind serial_reg_loader srl_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SHIFT_W(SHIFT_W)
) chk_i (
    .clk(clk), .rst(rst), .en_rise(en_rise), .en_fall(en_fall),
    .phase_data(phase_data), .shift_word(shift_word),
    .reg_flat(reg_flat), .wr_stb(wr_stb), .wr_addr(wr_addr)
);

// File: tb/serial_reg_loader_tb.sv
module serial_reg_loader_tb_top;
    localparam int NR = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_en = 1'b0;
    logic [NR*DW-1:0] reg_flat;
    logic       wr_stb;
    logic [7:0] wr_addr;

    int checks = 0;
    int errors = 0;
    int stb_cycles = 0;
    logic [7:0] stb_last_addr = '0;
    logic [DW-1:0] stb_seen_val = '0;
    logic [DW-1:0] model [NR];

    always #4 clk = ~clk;

    serial_reg_loader dut_i (
        .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_en(ser_en), .reg_flat(reg_flat), .wr_stb(wr_stb), .wr_addr(wr_addr)
    );

    always @(posedge clk) begin
        if (wr_stb) begin
            stb_cycles    <= stb_cycles + 1;
            stb_last_addr <= wr_addr;
            stb_seen_val  <= reg_flat[wr_addr[2:0]*DW +: DW];
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [31:0] val, input int nbits);
        @(negedge clk); ser_en = 1'b1; idle(4);
        for (int b = nbits - 1; b >= 0; b--) begin
            ser_data = val[b]; idle(4);
            ser_clk = 1'b1;    idle(4);
            ser_clk = 1'b0;    idle(4);
        end
        ser_en = 1'b0; idle(8);
    endtask

    task automatic write_reg(input logic [31:0] a, input int abits,
                             input logic [31:0] d, input int dbits);
        send_frame(a, abits);
        send_frame(d, dbits);
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NR; i++)
            check(req, {16'h0, reg_flat[i*DW +: DW]}, {16'h0, model[i]});
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; idle(3); rst = 1'b0; idle(2);
        for (int i = 0; i < NR; i++) model[i] = '0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 bank zero", {31'h0, reg_flat == '0}, 32'h1);
        check("R1 strobe low", {31'h0, wr_stb}, 32'h0);
    endtask

    task automatic t_full_write();
        int s0 = stb_cycles;
        write_reg(32'h02, 8, 32'hA5C3, 16);
        model[2] = 16'hA5C3;
        check_bank("R2 R3 full 16-bit write MSB first");
        check("R8 one strobe cycle", stb_cycles - s0, 1);
        check("R8 strobe address", {24'h0, stb_last_addr}, 32'h02);
        check("R8 value visible with strobe", {16'h0, stb_seen_val}, 32'hA5C3);
    endtask

    task automatic t_short_data();
        write_reg(32'h05, 8, 32'h2D, 6);
        model[5] = 16'h002D;
        check_bank("R6 short frame right-justified");
    endtask

    task automatic t_long_addr();
        write_reg(32'hF04, 12, 32'h1234, 16);
        model[4] = 16'h1234;
        check_bank("R5 last 8 address bits kept");
    endtask

    task automatic t_long_data();
        write_reg(32'h06, 8, 32'hABCDE, 20);
        model[6] = 16'hBCDE;
        check_bank("R6 long frame keeps last 16 bits");
    endtask

    task automatic t_no_leak();
        write_reg(32'h01, 8, 32'h5, 3);
        model[1] = 16'h0005;
        check_bank("R4 no stale bits after long frame");
    endtask

    task automatic t_bad_addr();
        int s0 = stb_cycles;
        write_reg(32'h09, 8, 32'hFFFF, 16);
        write_reg(32'h08, 8, 32'hFFFF, 16);
        check_bank("R7 out-of-range write discarded");
        check("R7 no strobe out of range", stb_cycles - s0, 0);
        write_reg(32'h07, 8, 32'h8001, 16);
        model[7] = 16'h8001;
        check_bank("R7 top register written");
    endtask

    task automatic t_alternation();
        send_frame(32'h03, 8);
        send_frame(32'h0707, 16);
        send_frame(32'h00, 8);
        send_frame(32'h4242, 16);
        model[3] = 16'h0707;
        model[0] = 16'h4242;
        check_bank("R3 back-to-back frames alternate");
    endtask

    task automatic t_reset_mid();
        send_frame(32'h03, 8);
        do_reset();
        check("R9 reset clears bank", {31'h0, reg_flat == '0}, 32'h1);
        write_reg(32'h05, 8, 32'hBEEF, 16);
        model[5] = 16'hBEEF;
        check_bank("R9 frame after reset is an address");
    endtask

    initial begin
        for (int i = 0; i < NR; i++) model[i] = '0;
        t_reset_state();
        t_full_write();
        t_short_data();
        t_long_addr();
        t_long_data();
        t_no_leak();
        t_bad_addr();
        t_alternation();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule